// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block gives a processor 24 general-purpose port lines. They are arranged as two full 8-bit ports (A and B) and a third 8-bit port (C) that is split into an upper and a lower 4-bit half. Together they form two groups of twelve lines. Group one is port A plus the upper half of C. Group two is port B plus the lower half of C. Each of the four sections is independently an input or an output in basic I/O mode. The processor programs this through a control word written over a small synchronous register interface. The interface has two address bits, an active-low select, active-low read and write strobes, and an 8-bit data path.

Any write to the control address is one of two operations. A mode write defines the section directions and clears every output latch. A single-bit operation sets or clears one line of port C and leaves everything else alone. The control word can be read back. Port lines are modelled as separate input, output and output-enable vectors. A pad shell or a strobed handshake block sits outside this unit. Out of reset every section is an input, so the unit is usable without any programming.

Top module: `pio_port_ctrl`

## Requirements
- R1: After reset the control word reads back as 0x9B, every output enable is 0, and every output latch (pa_out, pb_out, pc_out) is 0xFF.
- R2: Register select is addr 00 = port A, 01 = port B, 10 = port C, 11 = control. rdata is 0 whenever cs_n or rd_n is high.
- R3: A control write with wdata bit 7 = 1 is a mode write. It stores the whole byte, and a later control read returns it unchanged.
- R4: In the mode word a 1 means input and a 0 means output. Bit 4 sets port A, bit 3 sets port C bits 7:4, bit 1 sets port B, and bit 0 sets port C bits 3:0. Each enable bit of a section equals the inverse of its direction bit from the edge that takes the mode write onward, and changes at no other time.
- R5: A mode write clears pa_out, pb_out and pc_out to 0 at the same edge.
- R6: A control write with bit 7 = 0 is a single-bit operation. Bits 3:1 select a port C line and bit 0 is its new value. Only that line of pc_out changes, and the control word is left unchanged.
- R7: The single-bit operation updates the port C latch even when that half is set as input. The new value shows on pc_out and becomes visible on a read once the half is turned to output.
- R8: A data write to port A, B or C loads the whole byte into that port's latch at the write edge, whatever the port's direction.
- R9: A read of a section set as input returns its pins as sampled at the previous clock edge. A read of a section set as output returns its latch. Port C is muxed per half.
- R10: A write strobe with cs_n high changes no latch and no control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low select for reads and writes |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe, taken at the rising edge |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from stored state |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
Writes, mode changes and single-bit operations act at the rising edge that samples the strobe. Their effect on the latches and enables is therefore due one edge after the strobe is driven. Pin values reach rdata one edge after they are applied. A read of stored state is combinational in the same cycle as the strobe. The bench drives inputs just after the falling edge. Its reference model is updated at each rising edge, and it compares every output at the next falling edge. In that way each result is checked in the first cycle it is due. Directed checks read the control word and ports back in the cycle after each operation.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PORT_W = 8;
  localparam int HALF_W = PORT_W / 2;
  localparam int SEL_W  = $clog2(PORT_W);

  typedef enum logic [1:0] {
    SEL_A    = 2'b00,
    SEL_B    = 2'b01,
    SEL_C    = 2'b10,
    SEL_CTRL = 2'b11
  } sel_e;

  // control word fields
  localparam int MODE_FLAG = 7;
  localparam int DIR_A     = 4;
  localparam int DIR_CU    = 3;
  localparam int DIR_B     = 1;
  localparam int DIR_CL    = 0;

  localparam logic [PORT_W-1:0] CTRL_RST = 8'h9B;
endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_l
);
  logic q1, q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign rst_l = q2;
endmodule

// File: rtl/pio_bus_dec.sv
module pio_bus_dec
  import pio_pkg::*;
(
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic              mode_bit,
  input  logic [SEL_W:0]    bsr_fld,
  output logic              wr_a,
  output logic              wr_b,
  output logic              wr_c,
  output logic              wr_mode,
  output logic [PORT_W-1:0] bsr_en,
  output logic              bsr_val,
  output logic              rd_en
);
  logic wr_act;
  logic wr_ctl;

  assign wr_act  = !cs_n && !wr_n;
  assign rd_en   = !cs_n && !rd_n;
  assign wr_a    = wr_act && (sel_e'(addr) == SEL_A);
  assign wr_b    = wr_act && (sel_e'(addr) == SEL_B);
  assign wr_c    = wr_act && (sel_e'(addr) == SEL_C);
  assign wr_ctl  = wr_act && (sel_e'(addr) == SEL_CTRL);
  assign wr_mode = wr_ctl && mode_bit;
  assign bsr_val = bsr_fld[0];

  always_comb begin
    bsr_en = '0;
    if (wr_ctl && !mode_bit)
      bsr_en[bsr_fld[SEL_W:1]] = 1'b1;
  end
endmodule

// File: rtl/pio_ctrl_reg.sv
module pio_ctrl_reg
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_l,
  input  logic              wr_mode,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] ctrl
);
  logic [PORT_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en;

  assign ctrl_en = wr_mode;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_en) ctrl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) ctrl_q <= CTRL_RST;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/pio_port_sec.sv
module pio_port_sec #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_l,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] bit_en,
  input  logic         bit_val,
  input  logic         dir_in,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] lat_q, lat_d;
  logic [W-1:0] smp_q;
  logic         lat_en;

  assign lat_en = clr || wr_en || (|bit_en);

  always_comb begin
    lat_d = lat_q;
    if (clr)        lat_d = '0;
    else if (wr_en) lat_d = wr_data;
    else begin
      for (int i = 0; i < W; i++)
        if (bit_en[i]) lat_d[i] = bit_val;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l)      lat_q <= '1;
    else if (lat_en) lat_q <= lat_d;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) smp_q <= '0;
    else        smp_q <= pin_in;
  end

  assign pin_out = lat_q;
  assign pin_oe  = {W{~dir_in}};
  assign rd_val  = dir_in ? smp_q : lat_q;
endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] rdata,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe
);
  logic              rst_l;
  logic              wr_a, wr_b, wr_c, wr_mode, bsr_val, rd_en;
  logic [PORT_W-1:0] bsr_en;
  logic [PORT_W-1:0] ctrl;
  logic [PORT_W-1:0] rd_a, rd_b, rd_c;

  pio_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_l (rst_l)
  );

  pio_bus_dec u_dec (
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .mode_bit (wdata[MODE_FLAG]),
    .bsr_fld  (wdata[SEL_W:0]),
    .wr_a     (wr_a),
    .wr_b     (wr_b),
    .wr_c     (wr_c),
    .wr_mode  (wr_mode),
    .bsr_en   (bsr_en),
    .bsr_val  (bsr_val),
    .rd_en    (rd_en)
  );

  pio_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_l   (rst_l),
    .wr_mode (wr_mode),
    .wdata   (wdata),
    .ctrl    (ctrl)
  );

  pio_port_sec #(.W(PORT_W)) u_pa (
    .clk     (clk),
    .rst_l   (rst_l),
    .clr     (wr_mode),
    .wr_en   (wr_a),
    .wr_data (wdata),
    .bit_en  ('0),
    .bit_val (1'b0),
    .dir_in  (ctrl[DIR_A]),
    .pin_in  (pa_in),
    .pin_out (pa_out),
    .pin_oe  (pa_oe),
    .rd_val  (rd_a)
  );

  pio_port_sec #(.W(PORT_W)) u_pb (
    .clk     (clk),
    .rst_l   (rst_l),
    .clr     (wr_mode),
    .wr_en   (wr_b),
    .wr_data (wdata),
    .bit_en  ('0),
    .bit_val (1'b0),
    .dir_in  (ctrl[DIR_B]),
    .pin_in  (pb_in),
    .pin_out (pb_out),
    .pin_oe  (pb_oe),
    .rd_val  (rd_b)
  );

  // port C: two independently directed halves
  for (genvar gi = 0; gi < 2; gi++) begin : g_pc
    localparam int DBIT = (gi == 0) ? DIR_CL : DIR_CU;
    pio_port_sec #(.W(HALF_W)) u_half (
      .clk     (clk),
      .rst_l   (rst_l),
      .clr     (wr_mode),
      .wr_en   (wr_c),
      .wr_data (wdata[gi*HALF_W +: HALF_W]),
      .bit_en  (bsr_en[gi*HALF_W +: HALF_W]),
      .bit_val (bsr_val),
      .dir_in  (ctrl[DBIT]),
      .pin_in  (pc_in[gi*HALF_W +: HALF_W]),
      .pin_out (pc_out[gi*HALF_W +: HALF_W]),
      .pin_oe  (pc_oe[gi*HALF_W +: HALF_W]),
      .rd_val  (rd_c[gi*HALF_W +: HALF_W])
    );
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (sel_e'(addr))
        SEL_A:    rdata = rd_a;
        SEL_B:    rdata = rd_b;
        SEL_C:    rdata = rd_c;
        SEL_CTRL: rdata = ctrl;
      endcase
    end
  end
endmodule

// File: rtl/pio_port_ctrl_chk.sv
module pio_port_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] pa_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_out,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_out,
  input logic [7:0] pc_oe
);
  logic [1:0] arm_cnt;
  logic       armed;
  logic       wr_any, wr_mode, wr_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          arm_cnt <= '0;
    else if (!(&arm_cnt)) arm_cnt <= arm_cnt + 2'd1;
  end
  assign armed   = &arm_cnt;
  assign wr_any  = !cs_n && !wr_n;
  assign wr_mode = wr_any && (addr == 2'b11) && wdata[7];
  assign wr_bit  = wr_any && (addr == 2'b11) && !wdata[7];

  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(wr_mode) |-> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00)); // R5

  AST_BIT_OP_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(wr_bit) |-> ($countones(pc_out ^ $past(pc_out)) <= 1 && $stable(pa_out) && $stable(pb_out))); // R6

  AST_IDLE_HOLDS_LATCHES: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(wr_any) |-> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out))); // R10

  AST_OE_ONLY_ON_MODE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(wr_mode) |-> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe))); // R4

  AST_MODE_SETS_DIR: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(wr_mode) |-> (pa_oe == {8{~$past(wdata[4])}} && pb_oe == {8{~$past(wdata[1])}})); // R4

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (rdata == 8'h00)); // R2
endmodule

bind pio_port_ctrl pio_port_ctrl_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_n   (cs_n),
  .rd_n   (rd_n),
  .wr_n   (wr_n),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .pa_out (pa_out),
  .pa_oe  (pa_oe),
  .pb_out (pb_out),
  .pb_oe  (pb_oe),
  .pc_out (pc_out),
  .pc_oe  (pc_oe)
);

// File: tb/pio_port_ctrl_tb.sv
`timescale 1ns/1ps
module pio_port_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int n_run = 0, n_fail = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  // reference state
  logic [7:0] m_ctrl, m_a, m_b, m_c, m_sa, m_sb, m_sc;

  always #4 clk = ~clk;

  pio_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%02h exp=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= 8'h9B; m_a <= 8'hFF; m_b <= 8'hFF; m_c <= 8'hFF;
      m_sa <= '0; m_sb <= '0; m_sc <= '0;
    end else begin
      m_sa <= pa_in; m_sb <= pb_in; m_sc <= pc_in;
      if (!cs_n && !wr_n) begin
        case (addr)
          2'd0: m_a <= wdata;
          2'd1: m_b <= wdata;
          2'd2: m_c <= wdata;
          default: begin
            if (wdata[7]) begin
              m_ctrl <= wdata; m_a <= '0; m_b <= '0; m_c <= '0;
            end else begin
              m_c[wdata[3:1]] <= wdata[0];
            end
          end
        endcase
      end
    end
  end

  function automatic logic [7:0] model_rd();
    logic [7:0] r;
    if (cs_n || rd_n) return 8'h00;
    case (addr)
      2'd0: r = m_ctrl[4] ? m_sa : m_a;
      2'd1: r = m_ctrl[1] ? m_sb : m_b;
      2'd2: r = {m_ctrl[3] ? m_sc[7:4] : m_c[7:4], m_ctrl[0] ? m_sc[3:0] : m_c[3:0]};
      default: r = m_ctrl;
    endcase
    return r;
  endfunction

  // cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (chk_on && !done) begin
      check("R8 pa_out", pa_out, m_a);
      check("R8 pb_out", pb_out, m_b);
      check("R6 pc_out", pc_out, m_c);
      check("R4 pa_oe", pa_oe, {8{~m_ctrl[4]}});
      check("R4 pb_oe", pb_oe, {8{~m_ctrl[1]}});
      check("R4 pc_oe", pc_oe, {{4{~m_ctrl[3]}}, {4{~m_ctrl[0]}}});
      check("R9 rdata", rdata, model_rd());
    end
  end

  task automatic idle();
    @(negedge clk); #1;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); #1;
    cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1; addr = a; wdata = d;
    idle();
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [7:0] exp);
    @(negedge clk); #1;
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; addr = a;
    #1 check(req, rdata, exp);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk_on = 1'b1;
    // R1 reset state
    check("R1 pa_out", pa_out, 8'hFF);
    check("R1 pc_out", pc_out, 8'hFF);
    check("R1 oe", pa_oe | pb_oe | pc_oe, 8'h00);
    rd_chk("R1 ctrl", 2'd3, 8'h9B);
    // R9 input reads with pins one cycle stale
    @(negedge clk); #1 pa_in = 8'h5A; pc_in = 8'h3C; pb_in = 8'hC3;
    idle();
    rd_chk("R9 pa in", 2'd0, 8'h5A);
    rd_chk("R2 pb sel", 2'd1, 8'hC3);
    rd_chk("R9 pc in", 2'd2, 8'h3C);
    // R8 write while input still loads latch
    wr(2'd0, 8'h81);
    check("R8 latch in input mode", pa_out, 8'h81);
    // R3/R5 mode: all outputs
    wr(2'd3, 8'h80);
    check("R5 cleared", pa_out | pb_out | pc_out, 8'h00);
    check("R4 all out", pa_oe & pb_oe & pc_oe, 8'hFF);
    rd_chk("R3 readback", 2'd3, 8'h80);
    wr(2'd1, 8'hA5);
    rd_chk("R9 pb latch", 2'd1, 8'hA5);
    // R6 single-bit operation
    wr(2'd3, 8'h0B); // bit 5 set
    check("R6 set bit5", pc_out, 8'h20);
    wr(2'd3, 8'h01); // bit 0 set
    wr(2'd3, 8'h0A); // bit 5 clear
    check("R6 clear bit5", pc_out, 8'h01);
    rd_chk("R6 ctrl kept", 2'd3, 8'h80);
    // R10 write ignored without select
    @(negedge clk); #1 cs_n = 1'b1; wr_n = 1'b0; addr = 2'd3; wdata = 8'h9B;
    idle();
    check("R10 no mode", pa_oe, 8'hFF);
    check("R10 no clear", pb_out, 8'hA5);
    // R4/R7 mixed: A out, C upper in, B out, C lower out
    wr(2'd3, 8'h88);
    check("R4 pc_oe mixed", pc_oe, 8'h0F);
    wr(2'd3, 8'h0F); // bit 7 set on an input half
    check("R7 latch on input half", pc_out, 8'h80);
    rd_chk("R9 pc mixed", 2'd2, 8'h30);
    wr(2'd3, 8'h80); // upper half back to output, latch cleared
    wr(2'd3, 8'h0D); // bit 6 set
    rd_chk("R7 readable as output", 2'd2, 8'h40);
    // random traffic compared cycle by cycle
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk); #1;
      cs_n  = ($urandom_range(0, 3) == 0);
      wr_n  = ($urandom_range(0, 2) != 0);
      rd_n  = $urandom_range(0, 1);
      addr  = 2'($urandom_range(0, 3));
      wdata = 8'($urandom);
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
    end
    idle();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule